// File: doc/BRIEF.md
# Cascaded Capture Timer Pair

The block joins two 16-bit count channels into one 32-bit counter. The low channel advances on an external count clock, or it follows a two-phase quadrature encoder and counts in either direction. When the low half rolls over, the high half moves one step in the same direction. Each half has a capture register that loads its half of the count when a chosen edge arrives on that half's capture pin.

Two cross-enable bits let the edge that captures one half also capture the other half. With this set, a single pin event records the full 32-bit count at one instant, with no risk of tearing between the halves. Software sets up the mode, the edge selection and the counter values through a small write/read register port. It reads the counters and captures back through the same port.

Top module: `casc_cap_timer`

## Requirements
- R1: After reset, every register (both counters, both captures, control) reads 0.
- R2: With control bit 6 clear (external clock mode), each rising edge on `cnt_a_i` increments the low count by one. The count holds when no step arrives.
- R3: A low-count increment from 0xFFFF gives 0x0000 and adds one to the high count (0xFFFF wraps to 0x0000).
- R4: With control bit 6 set, the pin pair {`cnt_a_i`,`cnt_b_i`} moving forward through 00, 10, 11, 01 (A leads B) counts up by one per transition. Moving backward counts down by one per transition.
- R5: A low-count decrement from 0x0000 gives 0xFFFF and subtracts one from the high count.
- R6: In quadrature mode, a transition in which both pins change together leaves the count unchanged.
- R7: Control bits [1:0] select the low capture pin edge and bits [3:2] select the high capture pin edge, encoded as 00 none, 01 rising, 10 falling, 11 both.
- R8: A capture loads the count that was held before any update in the same cycle. A pin change and a count-pin change that arrive together capture the pre-increment value.
- R9: With control bit 4 set, a selected edge on the low capture pin also loads the high count into the high capture register.
- R10: With control bit 5 set, a selected edge on the high capture pin also loads the low count into the low capture register. With bit 5 clear, that pin leaves the low capture register unchanged.
- R11: A software write to a counter takes priority over a count step in the same cycle. Any counter write suppresses that cycle's step.
- R12: The register addresses are 0 low count, 1 high count, 2 low capture, 3 high capture and 4 control. Control holds bits [6:0], and the upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| cap_lo_i | input | 1 | Capture pin of the low channel |
| cap_hi_i | input | 1 | Capture pin of the high channel |
| cnt_a_i | input | 1 | External count clock, or phase A of the encoder |
| cnt_b_i | input | 1 | Phase B of the encoder |

## Verification
The assertions check the following on every cycle:
- carry and borrow between the halves;
- that a counter write beats a step;
- that the count holds without a step;
- that the up and down steps never occur together;
- that double quadrature transitions are dropped;
- that each capture register loads the count from the cycle before its trigger.

Some behaviour only the bench scenarios can show:
- the end-to-end pin-to-register latency;
- the four edge-select encodings;
- the cross-channel routing in both directions;
- the same-cycle race between a capture and a count step;
- the register map seen from the port.

// File: rtl/casc_tmr_pkg.sv
`timescale 1ns/1ps
package casc_tmr_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CNT_LO = 3'd0,
    REG_CNT_HI = 3'd1,
    REG_CAP_LO = 3'd2,
    REG_CAP_HI = 3'd3,
    REG_CTRL   = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      quad_mode;  // 6
    logic      xen_lo;     // 5
    logic      xen_hi;     // 4
    edge_sel_e edge_hi;    // 3:2
    edge_sel_e edge_lo;    // 1:0
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  function automatic logic edge_hit(edge_sel_e sel, logic lvl, logic prv);
    logic rise, fall;
    rise = lvl & ~prv;
    fall = ~lvl & prv;
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction
endpackage

// File: rtl/tmr_pin_sync.sv
`timescale 1ns/1ps
module tmr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic prv_o
);
  logic [STAGES-1:0] sync_q;
  logic              prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prv_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prv_q  <= sync_q[STAGES-1];
    end
  end

  assign lvl_o = sync_q[STAGES-1];
  assign prv_o = prv_q;
endmodule

// File: rtl/tmr_quad_dec.sv
`timescale 1ns/1ps
module tmr_quad_dec (
  input  logic [1:0] cur_ab_i,  // {a, b}
  input  logic [1:0] prv_ab_i,
  output logic       up_o,
  output logic       dn_o
);
  // gray position: 00->0, 10->1, 11->2, 01->3
  logic [1:0] cur_pos, prv_pos, delta;

  always_comb begin
    cur_pos = {cur_ab_i[0], cur_ab_i[1] ^ cur_ab_i[0]};
    prv_pos = {prv_ab_i[0], prv_ab_i[1] ^ prv_ab_i[0]};
    delta   = cur_pos - prv_pos;
    up_o    = (delta == 2'd1);
    dn_o    = (delta == 2'd3);
  end
endmodule

// File: rtl/tmr_casc_cnt.sv
`timescale 1ns/1ps
module tmr_casc_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          up_i,
  input  logic          dn_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] lo_o,
  output logic [CW-1:0] hi_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] CMIN = '0;

  logic [CW-1:0] lo_q, hi_q;
  logic          any_wr;

  assign any_wr = wr_lo_i | wr_hi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (any_wr) begin
      if (wr_lo_i) lo_q <= wdata_i;
      if (wr_hi_i) hi_q <= wdata_i;
    end else if (up_i) begin
      lo_q <= lo_q + 1'b1;
      if (lo_q == CMAX) hi_q <= hi_q + 1'b1;
    end else if (dn_i) begin
      lo_q <= lo_q - 1'b1;
      if (lo_q == CMIN) hi_q <= hi_q - 1'b1;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  AST_CARRY_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && !any_wr && lo_q == CMAX) |=> (lo_q == CMIN && hi_q == $past(hi_q) + 1'b1)); // R3
  AST_BORROW_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i && !up_i && !any_wr && lo_q == CMIN) |=> (lo_q == CMAX && hi_q == $past(hi_q) - 1'b1)); // R5
  AST_WR_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> lo_q == $past(wdata_i)); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_i && !dn_i && !any_wr) |=> ($stable(lo_q) && $stable(hi_q))); // R2
endmodule

// File: rtl/casc_cap_timer.sv
`timescale 1ns/1ps
module casc_cap_timer
  import casc_tmr_pkg::*;
#(
  parameter int unsigned CW          = CNT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CW-1:0]     wdata_i,
  output logic [CW-1:0]     rdata_o,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  input  logic              cnt_a_i,
  input  logic              cnt_b_i
);
  localparam int unsigned NPIN = 4;
  localparam int unsigned P_CLO = 0, P_CHI = 1, P_A = 2, P_B = 3;

  logic [NPIN-1:0] pin_raw, pin_lvl, pin_prv;
  assign pin_raw = {cnt_b_i, cnt_a_i, cap_hi_i, cap_lo_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_raw[g]),
      .lvl_o (pin_lvl[g]),
      .prv_o (pin_prv[g])
    );
  end

  ctrl_t   ctrl_q;
  logic    wr_lo, wr_hi, wr_ctrl;
  logic    q_up, q_dn, step_up, step_dn, a_rise;
  logic    lo_hit, hi_hit, cap_lo_trig, cap_hi_trig;
  logic [CW-1:0] cnt_lo, cnt_hi, cap_lo_q, cap_hi_q;

  assign wr_lo   = wr_en_i && (addr_i == REG_CNT_LO);
  assign wr_hi   = wr_en_i && (addr_i == REG_CNT_HI);
  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);

  tmr_quad_dec u_quad (
    .cur_ab_i({pin_lvl[P_A], pin_lvl[P_B]}),
    .prv_ab_i({pin_prv[P_A], pin_prv[P_B]}),
    .up_o    (q_up),
    .dn_o    (q_dn)
  );

  assign a_rise  = pin_lvl[P_A] & ~pin_prv[P_A];
  assign step_up = ctrl_q.quad_mode ? q_up : a_rise;
  assign step_dn = ctrl_q.quad_mode & q_dn;

  tmr_casc_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .up_i   (step_up),
    .dn_i   (step_dn),
    .wr_lo_i(wr_lo),
    .wr_hi_i(wr_hi),
    .wdata_i(wdata_i),
    .lo_o   (cnt_lo),
    .hi_o   (cnt_hi)
  );

  assign lo_hit      = edge_hit(ctrl_q.edge_lo, pin_lvl[P_CLO], pin_prv[P_CLO]);
  assign hi_hit      = edge_hit(ctrl_q.edge_hi, pin_lvl[P_CHI], pin_prv[P_CHI]);
  assign cap_lo_trig = lo_hit | (ctrl_q.xen_lo & hi_hit);
  assign cap_hi_trig = hi_hit | (ctrl_q.xen_hi & lo_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      cap_lo_q <= '0;
      cap_hi_q <= '0;
    end else begin
      if (wr_ctrl)     ctrl_q   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (cap_lo_trig) cap_lo_q <= cnt_lo;
      if (cap_hi_trig) cap_hi_q <= cnt_hi;
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_CNT_LO: rdata_o = cnt_lo;
      REG_CNT_HI: rdata_o = cnt_hi;
      REG_CAP_LO: rdata_o = cap_lo_q;
      REG_CAP_HI: rdata_o = cap_hi_q;
      REG_CTRL:   rdata_o = {{(CW-CTRL_W){1'b0}}, ctrl_q};
      default:    rdata_o = '0;
    endcase
  end

  AST_CAP_LO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_lo_trig |=> cap_lo_q == $past(cnt_lo)); // R8
  AST_CAP_HI_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hi_trig |=> cap_hi_q == $past(cnt_hi)); // R8
  AST_XEN_LO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.xen_lo && !lo_hit) |=> $stable(cap_lo_q)); // R10
  AST_QUAD_DOUBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.quad_mode && pin_lvl[P_A] != pin_prv[P_A] && pin_lvl[P_B] != pin_prv[P_B])
      |-> (!step_up && !step_dn)); // R6
  AST_STEP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_up && step_dn)); // R4
endmodule

// File: tb/casc_cap_timer_tb_top.sv
`timescale 1ns/1ps
module casc_cap_timer_tb_top;
  import casc_tmr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        cap_lo = 1'b0, cap_hi = 1'b0, cnt_a = 1'b0, cnt_b = 1'b0;

  int   n_chk = 0, n_err = 0;
  logic [1:0] qidx = 2'd0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  casc_cap_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cap_lo_i(cap_lo), .cap_hi_i(cap_hi),
    .cnt_a_i(cnt_a), .cnt_b_i(cnt_b)
  );

  typedef struct packed {
    logic        quad;
    logic        down;
    logic [3:0]  steps;
    logic [15:0] lo0, hi0, lo1, hi1;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b0, 4'd3, 16'h0005, 16'h0000, 16'h0008, 16'h0000},
    '{1'b0, 1'b0, 4'd3, 16'hFFFE, 16'h0012, 16'h0001, 16'h0013},
    '{1'b1, 1'b0, 4'd4, 16'h0000, 16'h0000, 16'h0004, 16'h0000},
    '{1'b1, 1'b1, 4'd3, 16'h0001, 16'h0007, 16'hFFFE, 16'h0006},
    '{1'b1, 1'b0, 4'd1, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000},
    '{1'b1, 1'b1, 4'd1, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_reg(string req, logic [2:0] a, logic [15:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  function automatic logic [1:0] seq(logic [1:0] i);
    case (i)
      2'd0: return 2'b00;
      2'd1: return 2'b10;
      2'd2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic quad_pins(logic up);
    qidx = up ? qidx + 2'd1 : qidx - 2'd1;
    {cnt_a, cnt_b} = seq(qidx);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic ext_pulse();
    cnt_a = 1'b1; settle();
    cnt_a = 1'b0; settle();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_reg("R1 cnt_lo", REG_CNT_LO, 16'h0);
    chk_reg("R1 cnt_hi", REG_CNT_HI, 16'h0);
    chk_reg("R1 cap_lo", REG_CAP_LO, 16'h0);
    chk_reg("R1 cap_hi", REG_CAP_HI, 16'h0);
    chk_reg("R1 ctrl",   REG_CTRL,   16'h0);
    // R12 control width
    wr(REG_CTRL, 16'hFFFF);
    chk_reg("R12 ctrl readback", REG_CTRL, 16'h007F);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      wr(REG_CTRL, {9'd0, VEC[i].quad, 6'd0});
      wr(REG_CNT_LO, VEC[i].lo0);
      wr(REG_CNT_HI, VEC[i].hi0);
      for (int s = 0; s < int'(VEC[i].steps); s++) begin
        if (VEC[i].quad) begin
          quad_pins(!VEC[i].down);
          settle();
        end else begin
          ext_pulse();
        end
      end
      chk_reg($sformatf("R2/R3/R4/R5 vec %0d lo", i), REG_CNT_LO, VEC[i].lo1);
      chk_reg($sformatf("R2/R3/R4/R5 vec %0d hi", i), REG_CNT_HI, VEC[i].hi1);
    end

    // R9 low pin snaps both halves
    wr(REG_CTRL, 16'h0051);
    wr(REG_CNT_LO, 16'h1234); wr(REG_CNT_HI, 16'hABCD);
    cap_lo = 1'b1; settle(); cap_lo = 1'b0; settle();
    chk_reg("R9 cap_lo", REG_CAP_LO, 16'h1234);
    chk_reg("R9 cap_hi", REG_CAP_HI, 16'hABCD);

    // R10 cross bit clear: high pin leaves low capture
    wr(REG_CTRL, 16'h0045);
    wr(REG_CNT_LO, 16'h0055); wr(REG_CNT_HI, 16'h0066);
    cap_hi = 1'b1; settle(); cap_hi = 1'b0; settle();
    chk_reg("R10 cap_hi", REG_CAP_HI, 16'h0066);
    chk_reg("R10 cap_lo unchanged", REG_CAP_LO, 16'h1234);

    // R10 cross bit set
    wr(REG_CTRL, 16'h0064);
    wr(REG_CNT_LO, 16'h0077); wr(REG_CNT_HI, 16'h0088);
    cap_hi = 1'b1; settle(); cap_hi = 1'b0; settle();
    chk_reg("R10 xen cap_lo", REG_CAP_LO, 16'h0077);
    chk_reg("R10 xen cap_hi", REG_CAP_HI, 16'h0088);

    // R7 falling only
    wr(REG_CTRL, 16'h0042);
    wr(REG_CNT_LO, 16'h0100);
    cap_lo = 1'b1; settle();
    chk_reg("R7 fall ignores rise", REG_CAP_LO, 16'h0077);
    wr(REG_CNT_LO, 16'h0101);
    cap_lo = 1'b0; settle();
    chk_reg("R7 fall captures", REG_CAP_LO, 16'h0101);

    // R7 none
    wr(REG_CTRL, 16'h0040);
    wr(REG_CNT_LO, 16'h0999);
    cap_lo = 1'b1; settle(); cap_lo = 1'b0; settle();
    chk_reg("R7 none", REG_CAP_LO, 16'h0101);

    // R7 both edges
    wr(REG_CTRL, 16'h0043);
    wr(REG_CNT_LO, 16'h0AAA);
    cap_lo = 1'b1; settle();
    chk_reg("R7 both rise", REG_CAP_LO, 16'h0AAA);
    wr(REG_CNT_LO, 16'h0BBB);
    cap_lo = 1'b0; settle();
    chk_reg("R7 both fall", REG_CAP_LO, 16'h0BBB);

    // R8 capture and step in the same cycle
    wr(REG_CTRL, 16'h0041);
    wr(REG_CNT_LO, 16'h0300); wr(REG_CNT_HI, 16'h0000);
    cap_lo = 1'b1; quad_pins(1'b1);
    settle();
    chk_reg("R8 pre-update capture", REG_CAP_LO, 16'h0300);
    chk_reg("R8 count stepped", REG_CNT_LO, 16'h0301);
    cap_lo = 1'b0; settle();

    // R11 write collides with a step
    wr(REG_CNT_LO, 16'h0010); wr(REG_CNT_HI, 16'h0003);
    quad_pins(1'b1);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b1; addr = REG_CNT_LO; wdata = 16'h5A5A;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    settle();
    chk_reg("R11 write wins", REG_CNT_LO, 16'h5A5A);
    chk_reg("R11 hi untouched", REG_CNT_HI, 16'h0003);

    // R6 double transition
    qidx = qidx + 2'd2;
    {cnt_a, cnt_b} = seq(qidx);
    settle();
    chk_reg("R6 double ignored", REG_CNT_LO, 16'h5A5A);
    quad_pins(1'b1); settle();
    chk_reg("R6 resumes after double", REG_CNT_LO, 16'h5A5B);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule